// File: doc/BRIEF.md
# Register-Level Display DDC Controller Serving a Local EDID Image

This block presents four 32-bit registers to a host: port select, command, status and data. To the host it looks like a display-channel I2C controller, but no bus is ever driven. A command word is decoded into a slave address, a starting index, a byte total and a cycle type. The block tracks an idle, data or wait phase and keeps a small set of status flags current. Each read of the data register hands back up to four bytes of an EDID image held in local storage. The image is filled through a byte-wide load port. A per-port vector reports whether a monitor is attached and whether that monitor is a DisplayPort sink.

Register access goes through a simple strobe bus. `reg_wr` and `reg_rd` are single-cycle strobes that qualify `reg_addr`. The addresses are 0 for select, 1 for command, 2 for status and 3 for data. Read data appears on `reg_rdata` on the clock edge that follows the read strobe. If both strobes are high in the same cycle, the write is performed and the read is dropped.

Status bit layout:
- bit 0: hardware-ready.
- bit 1: slave-timeout/error.
- bit 2: ACTIVE.
- bit 3: wait-phase flag.
- bit 4: interrupt. It always reads 0, because nothing in the block raises it.
- bit 5: IN_USE.
- bits 7:6: phase, encoded 0 for idle, 1 for data and 2 for wait.

Command layout:
- bit 31: software clear-interrupt.
- bit 30: software-ready.
- bits 27:25: cycle type, encoded as {stop, index, wait}.
- bits 24:16: byte total.
- bits 15:8: index.
- bits 7:1: slave address.
- bit 0: read direction.

The port codes 2, 4, 5 and 6 map to monitor ports 0, 1, 2 and 3.

Top module: `ddc_edid_regs`

## Requirements
- R1: After reset, the select, command and data registers read 0 and status reads 0x01 (hardware-ready only, phase idle).
- R2: A select write whose low 3 bits are 2, 4, 5 or 6 does the following:
  - It clears the transfer state.
  - It sets the phase to idle, clears ACTIVE, and sets hardware-ready and the wait-phase flag.
  - If the mapped port has a monitor that is not DisplayPort, it marks EDID available and clears the error flag.
- R3: A valid select to a port with no monitor, or with a DisplayPort monitor, sets the error flag and leaves EDID unavailable. A select code of 0, 1, 3 or 7 clears the transfer state and leaves status unchanged.
- R4: Only slave address 0x50 in command bits 7:1 selects the slave. With any other address, fetched bytes read as 0x00.
- R5: When command bit 26 (index) is set, the byte pointer is loaded from bits 15:8. Otherwise the pointer is kept.
- R6: Cycle types 1, 3, 5 and 7 set ACTIVE and the data phase. Types 0, 2 and 6 leave the phase unchanged. Whenever the phase is data, ACTIVE is set.
- R7: A stop command (type 4) issued after a command with a non-zero cycle type does three things: it clears the transfer state, returns the phase to idle and clears ACTIVE. A stop issued after a type-0 command has no effect.
- R8: A data read with command bit 0 set fetches min(4, total - pointer) bytes and packs them little-endian, first byte in bits 7:0. Byte lanes beyond that count keep their previous value. The pointer advances by the number of bytes actually fetched.
- R9: A data read with no bytes left, or with command bit 0 clear, returns the stored data value unchanged.
- R10: After the read that delivers the last bytes, the phase is idle for cycle types 5 and 7 and wait otherwise, and the transfer state is cleared.
- R11: A fetch at pointer 128 or beyond, or with EDID unavailable, yields 0x00 and does not advance the pointer.
- R12: A status read returns the old value and then sets IN_USE. Writing 1 to bit 5 clears IN_USE. No status write changes any other bit.
- R13: Bit 30 of the stored command always reads 0. Writing bit 31 as 1 sets hardware-ready. While bit 31 is stored, a command write with bit 31 at 0 clears only that bit and sets status to hardware-ready, plus the error flag if EDID is unavailable.
- R14: Writes to the data register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| mon_present | input | 4 | Monitor attached, one bit per port |
| mon_is_dp | input | 4 | Attached monitor is a DisplayPort sink |
| edid_we | input | 1 | EDID image byte write enable |
| edid_addr | input | 7 | EDID image byte address |
| edid_byte | input | 8 | EDID image byte value |

## Verification
The assertions check four things on every cycle:
- The phase encoding stays legal, and the data phase always coincides with ACTIVE.
- A data read moves the pointer forward by at most four and never past the end of the image.
- A data-register write leaves the stored word untouched.
- A status read leaves IN_USE set, and a command readback never shows the software-ready bit.

Other behaviour only the directed scenarios can show. This covers the exact packed byte values, lanes that keep stale bytes, and the idle-versus-wait phase at the end of a transfer. It also covers the monitor-type decision at port select, stop handling that depends on the previous cycle type, and the clear-interrupt handshake.

// File: rtl/ddc_edid_pkg.sv
package ddc_edid_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_DATA = 2'd1,
      PH_WAIT = 2'd2
   } ddc_phase_e;

   localparam logic [1:0] A_SEL = 2'd0;
   localparam logic [1:0] A_CMD = 2'd1;
   localparam logic [1:0] A_STS = 2'd2;
   localparam logic [1:0] A_DAT = 2'd3;

   localparam int C_CLRINT = 31;
   localparam int C_SWRDY  = 30;
   localparam int C_INDEX  = 26;
   localparam int C_READ   = 0;

   localparam int S_INUSE  = 5;

   localparam logic [2:0] CY_NONE = 3'd0;
   localparam logic [2:0] CY_STOP = 3'd4;

   typedef struct packed {
      logic       valid;
      logic [1:0] idx;
   } port_map_t;

   function automatic port_map_t map_port(input logic [2:0] code);
      port_map_t m;
      case (code)
         3'd2:    m = '{valid: 1'b1, idx: 2'd0};
         3'd4:    m = '{valid: 1'b1, idx: 2'd1};
         3'd5:    m = '{valid: 1'b1, idx: 2'd2};
         3'd6:    m = '{valid: 1'b1, idx: 2'd3};
         default: m = '{valid: 1'b0, idx: 2'd0};
      endcase
      return m;
   endfunction

endpackage

// File: rtl/ddc_edid_store.sv
module ddc_edid_store #(
   parameter int DEPTH = 128,
   parameter int LANES = 4,
   parameter int PW    = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [AW-1:0]        waddr,
   input  logic [7:0]           wbyte,
   input  logic [PW-1:0]        base,
   output logic [LANES*8-1:0]   lane_byte,
   output logic [LANES-1:0]     lane_in_range
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wbyte;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [PW:0] a;
      always_comb begin
         a = {1'b0, base} + (PW+1)'(i);
         lane_in_range[i] = (a < (PW+1)'(DEPTH));
         lane_byte[i*8 +: 8] = lane_in_range[i] ? mem[a[AW-1:0]] : 8'h00;
      end
   end

endmodule

// File: rtl/ddc_edid_packer.sv
module ddc_edid_packer #(
   parameter int LANES = 4,
   parameter int PW    = 9,
   parameter int CW    = 9,
   localparam int LW   = PW + 2,
   localparam int VW   = $clog2(LANES + 1)
) (
   input  logic [CW-1:0]       total,
   input  logic [PW-1:0]       ptr,
   input  logic                src_ok,
   input  logic [LANES-1:0]    lane_in_range,
   input  logic [LANES*8-1:0]  lane_byte,
   input  logic [LANES*8-1:0]  old_word,
   output logic                pending,
   output logic                last_chunk,
   output logic [LANES*8-1:0]  new_word,
   output logic [VW-1:0]       adv
);

   logic signed [LW-1:0] left;
   logic [LANES-1:0]     take;
   logic [LANES-1:0]     good;

   always_comb begin
      left       = $signed({{(LW-CW){1'b0}}, total}) - $signed({{(LW-PW){1'b0}}, ptr});
      pending    = (left > $signed(LW'(0)));
      last_chunk = (left <= $signed(LW'(LANES)));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_pack
      always_comb begin
         take[i] = (left > $signed(LW'(i)));
         good[i] = take[i] & src_ok & lane_in_range[i];
         if (!take[i])
            new_word[i*8 +: 8] = old_word[i*8 +: 8];
         else if (good[i])
            new_word[i*8 +: 8] = lane_byte[i*8 +: 8];
         else
            new_word[i*8 +: 8] = 8'h00;
      end
   end

   always_comb begin
      adv = '0;
      for (int k = 0; k < LANES; k++) adv = adv + VW'(good[k]);
   end

endmodule

// File: rtl/ddc_edid_regs.sv
module ddc_edid_regs #(
   parameter int          EDID_BYTES = 128,
   parameter logic [6:0]  SLAVE_ID   = 7'h50,
   localparam int         AW         = $clog2(EDID_BYTES),
   localparam int         LANES      = 4,
   localparam int         PW         = 9,
   localparam int         CW         = 9,
   localparam int         VW         = $clog2(LANES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic [3:0]    mon_present,
   input  logic [3:0]    mon_is_dp,
   input  logic          edid_we,
   input  logic [AW-1:0] edid_addr,
   input  logic [7:0]    edid_byte
);
   import ddc_edid_pkg::*;

   if (EDID_BYTES < LANES || EDID_BYTES > 256) begin : g_bad_depth
      $error("EDID_BYTES must lie in 4..256");
   end

   logic [31:0]  sel_q, cmd_q, data_q, rdata_q;
   logic [31:0]  n_sel, n_cmd, n_data, n_rdata;
   logic         hwrdy_q, err_q, active_q, waitf_q, inuse_q;
   logic         n_hwrdy, n_err, n_active, n_waitf, n_inuse;
   ddc_phase_e   phase_q, n_phase;
   logic         slave_q, avail_q, n_slave, n_avail;
   logic [PW-1:0] ptr_q, n_ptr;
   logic [CW-1:0] total_q, n_total;
   logic [2:0]   cyc_q, n_cyc;

   logic [LANES*8-1:0] lane_byte;
   logic [LANES-1:0]   lane_in_range;
   logic               pending, last_chunk;
   logic [31:0]        packed_word;
   logic [VW-1:0]      adv;
   logic [31:0]        sts_word;
   logic [31:0]        wv;
   port_map_t          pm;

   ddc_edid_store #(.DEPTH(EDID_BYTES), .LANES(LANES), .PW(PW)) u_store (
      .clk           (clk),
      .we            (edid_we),
      .waddr         (edid_addr),
      .wbyte         (edid_byte),
      .base          (ptr_q),
      .lane_byte     (lane_byte),
      .lane_in_range (lane_in_range)
   );

   ddc_edid_packer #(.LANES(LANES), .PW(PW), .CW(CW)) u_pack (
      .total         (total_q),
      .ptr           (ptr_q),
      .src_ok        (slave_q & avail_q),
      .lane_in_range (lane_in_range),
      .lane_byte     (lane_byte),
      .old_word      (data_q),
      .pending       (pending),
      .last_chunk    (last_chunk),
      .new_word      (packed_word),
      .adv           (adv)
   );

   assign sts_word = {24'h0, phase_q, inuse_q, 1'b0, waitf_q, active_q, err_q, hwrdy_q};
   assign reg_rdata = rdata_q;

   always_comb begin
      n_sel = sel_q;   n_cmd = cmd_q;   n_data = data_q;  n_rdata = rdata_q;
      n_hwrdy = hwrdy_q; n_err = err_q; n_active = active_q;
      n_waitf = waitf_q; n_inuse = inuse_q; n_phase = phase_q;
      n_slave = slave_q; n_avail = avail_q; n_ptr = ptr_q;
      n_total = total_q; n_cyc = cyc_q;
      wv = reg_wdata & ~(32'h1 << C_SWRDY);
      pm = map_port(reg_wdata[2:0]);

      if (reg_wr) begin
         case (reg_addr)
            A_SEL: begin
               n_sel = reg_wdata;
               n_slave = 1'b0; n_avail = 1'b0; n_ptr = '0; n_total = '0; n_cyc = CY_NONE;
               if (pm.valid) begin
                  n_phase  = PH_IDLE;
                  n_active = 1'b0;
                  n_hwrdy  = 1'b1;
                  n_waitf  = 1'b1;
                  if (mon_present[pm.idx] && !mon_is_dp[pm.idx]) begin
                     n_avail = 1'b1;
                     n_err   = 1'b0;
                  end else begin
                     n_err   = 1'b1;
                  end
               end
            end
            A_CMD: begin
               if (cmd_q[C_CLRINT]) begin
                  if (!reg_wdata[C_CLRINT]) begin
                     n_cmd[C_CLRINT] = 1'b0;
                     n_hwrdy  = 1'b1;
                     n_err    = !avail_q;
                     n_active = 1'b0;
                     n_waitf  = 1'b0;
                     n_inuse  = 1'b0;
                     n_phase  = PH_IDLE;
                  end
               end else begin
                  if (reg_wdata[C_CLRINT]) n_hwrdy = 1'b1;
                  n_total = wv[24:16];
                  if (wv[7:1] == SLAVE_ID) n_slave = 1'b1;
                  if (wv[C_INDEX]) n_ptr = PW'(wv[15:8]);
                  n_cyc = wv[27:25];
                  case (wv[27:25])
                     CY_STOP: begin
                        if (cmd_q[27:25] != CY_NONE) begin
                           n_slave = 1'b0; n_avail = 1'b0; n_ptr = '0;
                           n_total = '0;   n_cyc = CY_NONE;
                           n_phase  = PH_IDLE;
                           n_active = 1'b0;
                        end
                     end
                     3'd1, 3'd3, 3'd5, 3'd7: begin
                        n_phase  = PH_DATA;
                        n_active = 1'b1;
                     end
                     default: ;
                  endcase
                  n_cmd = wv;
               end
            end
            A_STS: begin
               if (reg_wdata[S_INUSE]) n_inuse = 1'b0;
            end
            default: ;
         endcase
      end else if (reg_rd) begin
         case (reg_addr)
            A_SEL: n_rdata = sel_q;
            A_CMD: n_rdata = cmd_q;
            A_STS: begin
               n_rdata = sts_word;
               n_inuse = 1'b1;
            end
            default: begin
               if (cmd_q[C_READ] && pending) begin
                  n_data  = packed_word;
                  n_rdata = packed_word;
                  n_ptr   = ptr_q + PW'(adv);
                  if (last_chunk) begin
                     n_phase = (cyc_q == 3'd5 || cyc_q == 3'd7) ? PH_IDLE : PH_WAIT;
                     n_slave = 1'b0; n_avail = 1'b0; n_ptr = '0;
                     n_total = '0;   n_cyc = CY_NONE;
                  end
               end else begin
                  n_rdata = data_q;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0; cmd_q <= '0; data_q <= '0; rdata_q <= '0;
         hwrdy_q <= 1'b1; err_q <= 1'b0; active_q <= 1'b0;
         waitf_q <= 1'b0; inuse_q <= 1'b0; phase_q <= PH_IDLE;
         slave_q <= 1'b0; avail_q <= 1'b0; ptr_q <= '0;
         total_q <= '0; cyc_q <= CY_NONE;
      end else begin
         sel_q <= n_sel; cmd_q <= n_cmd; data_q <= n_data; rdata_q <= n_rdata;
         hwrdy_q <= n_hwrdy; err_q <= n_err; active_q <= n_active;
         waitf_q <= n_waitf; inuse_q <= n_inuse; phase_q <= n_phase;
         slave_q <= n_slave; avail_q <= n_avail; ptr_q <= n_ptr;
         total_q <= n_total; cyc_q <= n_cyc;
      end
   end

endmodule

// File: rtl/ddc_edid_chk.sv
module ddc_edid_chk #(
   parameter int EDID_BYTES = 128,
   parameter int LANES      = 4,
   parameter int PW         = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [1:0]    reg_addr,
   input logic [31:0]   reg_rdata,
   input logic [1:0]    phase,
   input logic          active,
   input logic          inuse,
   input logic [PW-1:0] ptr,
   input logic [31:0]   data_word
);

   logic rd_only;
   assign rd_only = reg_rd && !reg_wr;

   // R6
   phase_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3);

   // R6
   data_phase_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd1) |-> active);

   // R11
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == 2'd3) |=>
         (ptr == '0) ||
         ((int'(ptr) <= int'($past(ptr)) + LANES) &&
          ((int'($past(ptr)) >= EDID_BYTES) ? (ptr == $past(ptr)) : (int'(ptr) <= EDID_BYTES))));

   // R14
   data_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3) |=> $stable(data_word));

   // R12
   inuse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == 2'd2) |=> inuse);

   // R13
   sw_rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_only && reg_addr == 2'd1) |=> !reg_rdata[30]);

endmodule

bind ddc_edid_regs ddc_edid_chk #(.EDID_BYTES(EDID_BYTES), .LANES(LANES), .PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .phase     (phase_q),
   .active    (active_q),
   .inuse     (inuse_q),
   .ptr       (ptr_q),
   .data_word (data_q)
);

// File: tb/ddc_edid_regs_tb.sv
`timescale 1ns/1ps
module ddc_edid_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  mon_present = 4'b0, mon_is_dp = 4'b0;
   logic        edid_we = 1'b0;
   logic [6:0]  edid_addr = '0;
   logic [7:0]  edid_byte = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ddc_edid_regs u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mon_present(mon_present), .mon_is_dp(mon_is_dp),
      .edid_we(edid_we), .edid_addr(edid_addr), .edid_byte(edid_byte)
   );

   function automatic logic [7:0] eb(input int i);
      return 8'((i * 7 + 3) & 255);
   endfunction

   function automatic logic [31:0] mkcmd(input logic [2:0] cyc, input int total,
                                         input int idx, input logic [6:0] sa, input logic rd);
      return {4'b0, cyc, 9'(total), 8'(idx), sa, rd};
   endfunction

   function automatic logic [31:0] pk(input int a, input int b, input int c, input int d);
      return {eb(d), eb(c), eb(b), eb(a)};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic chk_reg(input string req, input logic [1:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   // read status, compare, then drop IN_USE again
   task automatic chk_sts(input string req, input logic [31:0] exp);
      chk_reg(req, 2'd2, exp);
      wr(2'd2, 32'h20);
   endtask

   task automatic t_reset();
      chk_reg("R1 select", 2'd0, 32'h0);
      chk_reg("R1 command", 2'd1, 32'h0);
      chk_reg("R1 data", 2'd3, 32'h0);
      chk_sts("R1 status", 32'h01);
   endtask

   task automatic t_select_ok();
      mon_present = 4'b0001; mon_is_dp = 4'b0000;
      wr(2'd0, 32'h2);
      chk_reg("R2 select readback", 2'd0, 32'h2);
      chk_sts("R2 status after select", 32'h09);
   endtask

   task automatic t_indexed_stop();
      wr(2'd1, mkcmd(3'd7, 10, 5, 7'h50, 1'b1));
      chk_sts("R6 data phase", 32'h4D);
      chk_reg("R8 R5 first word", 2'd3, pk(5, 6, 7, 8));
      chk_reg("R8 partial word", 2'd3, {eb(8), eb(7), eb(6), eb(9)});
      chk_sts("R10 idle after stop-cycle", 32'h0D);
      chk_reg("R9 exhausted read", 2'd3, {eb(8), eb(7), eb(6), eb(9)});
   endtask

   task automatic t_wait_cycle();
      wr(2'd0, 32'h2);
      wr(2'd1, mkcmd(3'd3, 8, 4, 7'h50, 1'b1));
      chk_reg("R8 wait cycle word", 2'd3, pk(4, 5, 6, 7));
      chk_sts("R10 wait phase", 32'h8D);
   endtask

   task automatic t_nonindexed_partial();
      wr(2'd0, 32'h2);
      wr(2'd1, mkcmd(3'd5, 3, 0, 7'h50, 1'b1));
      chk_reg("R8 stale lane kept", 2'd3, {eb(7), eb(2), eb(1), eb(0)});
   endtask

   task automatic t_boundary();
      wr(2'd0, 32'h2);
      wr(2'd1, mkcmd(3'd3, 200, 126, 7'h50, 1'b1));
      chk_reg("R11 end of image", 2'd3, {16'h0, eb(127), eb(126)});
      chk_reg("R11 beyond image", 2'd3, 32'h0);
      chk_sts("R11 still in data phase", 32'h4D);
   endtask

   task automatic t_unavailable();
      mon_present = 4'b0101; mon_is_dp = 4'b0100;
      wr(2'd0, 32'h4);
      chk_sts("R3 no monitor error", 32'h0B);
      wr(2'd1, mkcmd(3'd7, 4, 0, 7'h50, 1'b1));
      chk_reg("R11 unavailable zeros", 2'd3, 32'h0);
      wr(2'd0, 32'h2);
      chk_sts("R2 error cleared", 32'h09);
      wr(2'd0, 32'h5);
      chk_sts("R3 dp monitor error", 32'h0B);
   endtask

   task automatic t_invalid_code();
      wr(2'd0, 32'h2);
      chk_sts("R2 reselect", 32'h09);
      wr(2'd0, 32'h3);
      chk_sts("R3 invalid code status kept", 32'h09);
      wr(2'd1, mkcmd(3'd7, 4, 0, 7'h50, 1'b1));
      chk_reg("R3 invalid code state reset", 2'd3, 32'h0);
   endtask

   task automatic t_wrong_slave();
      wr(2'd0, 32'h2);
      wr(2'd1, mkcmd(3'd7, 4, 0, 7'h51, 1'b1));
      chk_reg("R4 wrong slave zeros", 2'd3, 32'h0);
   endtask

   task automatic t_stop();
      wr(2'd0, 32'h2);
      wr(2'd1, mkcmd(3'd1, 8, 0, 7'h50, 1'b1));
      chk_sts("R6 wait-type enters data", 32'h4D);
      wr(2'd1, mkcmd(3'd4, 0, 0, 7'h0, 1'b0));
      chk_sts("R7 stop after cycle", 32'h09);
      wr(2'd1, mkcmd(3'd1, 8, 0, 7'h50, 1'b1));
      wr(2'd1, mkcmd(3'd0, 8, 0, 7'h50, 1'b1));
      wr(2'd1, mkcmd(3'd4, 0, 0, 7'h0, 1'b0));
      chk_sts("R7 stop after no-cycle ignored", 32'h4D);
   endtask

   task automatic t_in_use();
      logic [31:0] v;
      rd(2'd2, v);
      check("R12 old value returned", v, 32'h4D);
      rd(2'd2, v);
      check("R12 in-use set", v, 32'h6D);
      wr(2'd2, 32'hFFFF_FFDF);
      rd(2'd2, v);
      check("R12 other bits read-only", v, 32'h6D);
      wr(2'd2, 32'h20);
      rd(2'd2, v);
      check("R12 in-use cleared", v, 32'h4D);
      wr(2'd2, 32'h20);
   endtask

   task automatic t_clr_int();
      wr(2'd0, 32'h2);
      wr(2'd1, 32'hC000_00A0);
      chk_reg("R13 sw-ready dropped", 2'd1, 32'h8000_00A0);
      chk_sts("R13 hw-ready", 32'h09);
      wr(2'd1, 32'h0);
      chk_reg("R13 clr-int cleared", 2'd1, 32'h0000_00A0);
      chk_sts("R13 status reset", 32'h01);
   endtask

   task automatic t_data_write();
      wr(2'd3, 32'hDEAD_BEEF);
      chk_reg("R14 data write ignored", 2'd3, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin
         @(negedge clk);
         edid_we = 1'b1; edid_addr = 7'(i); edid_byte = eb(i);
      end
      @(negedge clk);
      edid_we = 1'b0;
      rst_n = 1'b1;
      t_reset();
      t_select_ok();
      t_indexed_stop();
      t_wait_cycle();
      t_nonindexed_partial();
      t_boundary();
      t_unavailable();
      t_invalid_code();
      t_wrong_slave();
      t_stop();
      t_in_use();
      t_clr_int();
      t_data_write();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule